// File: doc/BRIEF.md
# Eight-Line Interrupt Controller Register Front End

This block is the byte-wide programming and status side of an eight-input priority interrupt controller. Software reaches it through two addresses. Address 0 takes the start-of-setup word and two kinds of run-time command. Address 1 takes the remaining setup words and, once setup is done, the mask register. Reads return the latched requests, the in-service set, the mask, or the result of a poll. The block holds the in-service register and the priority rotation offset. It raises `int_out` when an unmasked request outranks everything in service. On an acknowledge pulse it returns the interrupt vector.

Requests are latched on rising edges by a small edge-memory sub-block. A rotatable priority picker is instantiated once for each set of bits the block has to rank. Rank is measured from a rotation offset, so end-of-interrupt commands with rotation and rotate-on-acknowledge change the winner. Only one controller is modelled. Linking several controllers together is not part of this block.

Top module: `pic_cmd_if`

## Requirements
- R1: After synchronous reset, IRR, ISR, IMR, the rotation offset, read-select, poll, special-mask, auto-EOI, special-nested and rotate-on-acknowledge flags are all zero, the sequencer is in run mode and `int_out`/`vec_valid` are low. A write to address 0 with bit 4 set clears the same state, drives `int_out` low in the next cycle and makes the sequencer wait for the vector-base word.
- R2: After a setup-start word, the next address-1 write sets the vector base from bits 7:3 with bits 2:0 forced to zero. If bit 0 of the setup-start word was set, one more address-1 write follows, setting special-nested mode from bit 4 and auto-EOI from bit 1. Address-1 writes in run mode load IMR, and an address-1 read returns IMR.
- R3: A rising edge on `irq_in[i]` sets IRR bit i. A level held high does not set it again.
- R4: A line's rank is (line − offset) mod 8, and rank 0 wins. `int_out` is high, one cycle after the state change, when the best-ranked line of IRR & ~IMR ranks strictly better than the best-ranked line of the blocking in-service set. IMR bit 1 masks a line.
- R5: An `ack` pulse with a valid request returns vector base | line on `vec_out` with `vec_valid` high in the next cycle, clears that line's IRR bit and sets its ISR bit.
- R6: An `ack` with no valid request returns base | 7 and leaves ISR and IRR unchanged.
- R7: With auto-EOI on, an acknowledge does not set any ISR bit.
- R8: Command code 4 (address 0, bits 7:5, bits 4:3 zero) turns on rotate-on-acknowledge and code 0 turns it off. When it is on, each valid acknowledge sets the offset to line + 1.
- R9: Code 1 clears the ISR bit of the best-ranked in-service line. Code 5 does the same and sets the offset to that line + 1.
- R10: Code 3 clears the ISR bit of the line in bits 2:0. Code 7 does the same and sets the offset to that line + 1.
- R11: Code 6 sets the offset to (bits 2:0) + 1. Code 2 changes nothing.
- R12: A write to address 0 with bit 4 clear and bit 3 set is a mode word: bit 0 chooses ISR (1) or IRR (0) for address-0 reads, bit 2 arms a poll, and when bit 6 is set bit 5 loads special-mask mode. In special-mask mode, in-service lines that are masked do not block lower-ranked requests.
- R13: An address-0 read with a poll armed returns the winning line number, clears its IRR and ISR bits and disarms the poll. With nothing to deliver it returns 0x07.
- R14: In special-nested mode the ISR bit of line 2 is left out of the blocking set, so a new request on line 2 can interrupt while line 2 is in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored when `wr_en` is high) |
| addr | input | 1 | Register address, 0 or 1 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| ack | input | 1 | Acknowledge pulse (ignored during a register access) |
| vec_out | output | 8 | Vector from the last acknowledge |
| vec_valid | output | 1 | High for the cycle after an acknowledge |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest states to reach from the ports are the ones where the winner depends on several pieces of history at once. One is a rotated offset left by an earlier rotating EOI or rotating acknowledge. Another is a masked line still in service while special-mask mode is switched on. The stimulus builds each of these step by step through real command writes and acknowledges. It first puts a known line in service, then sends a second simultaneous request pair whose winner differs depending on whether the offset or mask state took effect. The spurious case is reached by acknowledging while the only request ranks below the in-service line. Special-nested mode is shown by re-raising line 2 while line 2 is still in service.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_MODE = 2'd2
  } seq_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF    = 3'd0,
    OP_EOI_NS     = 3'd1,
    OP_NOP        = 3'd2,
    OP_EOI_SP     = 3'd3,
    OP_ROT_ON     = 3'd4,
    OP_EOI_NS_ROT = 3'd5,
    OP_SET_PRI    = 3'd6,
    OP_EOI_SP_ROT = 3'd7
  } op_e;

  // bit positions inside written bytes
  localparam int B_START    = 4;
  localparam int B_MODEWORD = 3;
  localparam int B_RSEL     = 0;
  localparam int B_POLL     = 2;
  localparam int B_SMM_VAL  = 5;
  localparam int B_SMM_EN   = 6;
  localparam int B_NEED_FIN = 0;
  localparam int B_AEOI     = 1;
  localparam int B_SNM      = 4;

endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] lines,
  output logic [N-1:0] irr
);

  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      irr  <= '0;
      prev <= lines;
    end else begin
      irr  <= (irr & ~clr_bits) | (lines & ~prev);
      prev <= lines;
    end
  end

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]         bits,
  input  logic [$clog2(N)-1:0] offset,
  output logic [$clog2(N):0]   rank
);

  localparam int LW = $clog2(N);

  logic [LW-1:0] idx;

  // lowest rotated position with a set bit; N when empty
  always_comb begin
    rank = (LW+1)'(N);
    idx  = '0;
    for (int p = N - 1; p >= 0; p--) begin
      idx = offset + LW'(p);
      if (bits[idx]) rank = (LW+1)'(p);
    end
  end

endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int DW        = 8,
  parameter int CASC_LINE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               ack,
  output logic [DW-1:0]      vec_out,
  output logic               vec_valid,
  output logic               int_out
);

  localparam int LW     = $clog2(N_LINES);
  localparam int NPICK  = 3;
  localparam logic [LW:0] NONE = (LW+1)'(N_LINES);
  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASC_LINE;

  // programmable state
  logic [N_LINES-1:0] imr, isr;
  logic [LW-1:0]      offset;
  logic [DW-1:0]      base;
  logic               rsel, poll_arm, smm, aeoi, snm, rot_ack, need_fin;
  seq_e               seq;

  // request latch
  logic [N_LINES-1:0] irr, irr_clr;

  // decode
  logic    wr0, wr1, init_wr, mode_wr, op_wr, rd_op, poll_rd, ack_op;
  op_e     op;
  logic [LW-1:0] sel;

  assign wr0     = wr_en && !addr;
  assign wr1     = wr_en && addr;
  assign init_wr = wr0 && wr_data[B_START];
  assign mode_wr = wr0 && !wr_data[B_START] && wr_data[B_MODEWORD];
  assign op_wr   = wr0 && !wr_data[B_START] && !wr_data[B_MODEWORD];
  assign op      = op_e'(wr_data[DW-1:DW-3]);
  assign sel     = wr_data[LW-1:0];
  assign rd_op   = rd_en && !wr_en;
  assign poll_rd = rd_op && !addr && poll_arm;
  assign ack_op  = ack && !wr_en && !rd_en;

  // priority pickers: 0 pending, 1 blocking in-service, 2 raw in-service
  logic [N_LINES-1:0] pk_bits [NPICK];
  logic [LW:0]        pk_rank [NPICK];

  always_comb begin
    pk_bits[0] = irr & ~imr;
    pk_bits[1] = isr & ~(smm ? imr : '0) & ~(snm ? CASC_BIT : '0);
    pk_bits[2] = isr;
  end

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    pic_prio_pick #(.N(N_LINES)) u_pick (
      .bits  (pk_bits[g]),
      .offset(offset),
      .rank  (pk_rank[g])
    );
  end

  logic          req_go, eoi_any;
  logic [LW-1:0] req_line, eoi_line;

  assign req_go   = (pk_rank[0] < pk_rank[1]);
  assign req_line = pk_rank[0][LW-1:0] + offset;
  assign eoi_any  = (pk_rank[2] != NONE);
  assign eoi_line = pk_rank[2][LW-1:0] + offset;

  logic ack_take, poll_take;
  assign ack_take  = ack_op && req_go;
  assign poll_take = poll_rd && req_go;
  assign irr_clr   = (ack_take || poll_take) ? (N_LINES'(1) << req_line) : '0;

  pic_req_latch #(.N(N_LINES)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .clr_all (init_wr),
    .clr_bits(irr_clr),
    .lines   (irq_in),
    .irr     (irr)
  );

  // control state
  always_ff @(posedge clk) begin
    if (rst || init_wr) begin
      imr      <= '0;
      isr      <= '0;
      offset   <= '0;
      rsel     <= 1'b0;
      poll_arm <= 1'b0;
      smm      <= 1'b0;
      aeoi     <= 1'b0;
      snm      <= 1'b0;
      rot_ack  <= 1'b0;
      need_fin <= rst ? 1'b0 : wr_data[B_NEED_FIN];
      seq      <= rst ? SEQ_RUN : SEQ_BASE;
      if (rst) base <= '0;
    end else if (op_wr) begin
      unique case (op)
        OP_ROT_OFF: rot_ack <= 1'b0;
        OP_ROT_ON:  rot_ack <= 1'b1;
        OP_EOI_NS, OP_EOI_NS_ROT: begin
          if (eoi_any) begin
            isr[eoi_line] <= 1'b0;
            if (op == OP_EOI_NS_ROT) offset <= eoi_line + 1'b1;
          end
        end
        OP_EOI_SP:     isr[sel] <= 1'b0;
        OP_EOI_SP_ROT: begin
          isr[sel] <= 1'b0;
          offset   <= sel + 1'b1;
        end
        OP_SET_PRI:    offset <= sel + 1'b1;
        default: ;
      endcase
    end else if (mode_wr) begin
      rsel     <= wr_data[B_RSEL];
      poll_arm <= wr_data[B_POLL];
      if (wr_data[B_SMM_EN]) smm <= wr_data[B_SMM_VAL];
    end else if (wr1) begin
      unique case (seq)
        SEQ_BASE: begin
          base <= {wr_data[DW-1:LW], {LW{1'b0}}};
          seq  <= need_fin ? SEQ_MODE : SEQ_RUN;
        end
        SEQ_MODE: begin
          snm  <= wr_data[B_SNM];
          aeoi <= wr_data[B_AEOI];
          seq  <= SEQ_RUN;
        end
        default: imr <= wr_data[N_LINES-1:0];
      endcase
    end else if (poll_rd) begin
      poll_arm <= 1'b0;
      if (req_go) isr[req_line] <= 1'b0;
    end else if (ack_take) begin
      if (!aeoi)  isr[req_line] <= 1'b1;
      if (rot_ack) offset <= req_line + 1'b1;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      int_out   <= 1'b0;
    end else begin
      int_out   <= init_wr ? 1'b0 : req_go;
      vec_valid <= ack_op;
      if (ack_op)
        vec_out <= base | (req_go ? DW'(req_line) : DW'(N_LINES - 1));
      if (rd_op) begin
        if (addr)          rd_data <= DW'(imr);
        else if (poll_arm) rd_data <= req_go ? DW'(req_line) : DW'(N_LINES - 1);
        else               rd_data <= DW'(rsel ? isr : irr);
      end
    end
  end

  // R1
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> (isr == '0 && imr == '0 && !int_out && irr == '0));

  // R5
  ack_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ack_op |=> vec_valid);

  // R4
  pick_hit_chk: assert property (@(posedge clk) disable iff (rst)
    req_go |-> (irr[req_line] && !imr[req_line]));

  // R6
  spurious_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_op && !req_go) |=> $stable(isr));

  // R7
  aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_op && aeoi) |=> $stable(isr));

  // R10
  spec_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (op_wr && (op == OP_EOI_SP || op == OP_EOI_SP_ROT)) |=> !isr[$past(sel)]);

  // R13
  poll_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (poll_rd && req_go) |=> (!isr[$past(req_line)] && !poll_arm));

endmodule

// File: tb/pic_cmd_if_test.sv
module pic_cmd_if_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, rd_en, addr, ack;
  logic [7:0] wr_data, rd_data, irq_in, vec_out;
  logic       vec_valid, int_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_if uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in), .ack(ack),
    .vec_out(vec_out), .vec_valid(vec_valid), .int_out(int_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic rd_isr(output logic [7:0] v);
    wr(1'b0, 8'h0B);
    rd(1'b0, v);
    wr(1'b0, 8'h0A);
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = m;
    @(negedge clk);
    irq_in = 8'h00;
  endtask

  task automatic ack_chk(input string tag, input logic [7:0] exp);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({tag, " vector"}, vec_out, exp);
    chk({tag, " valid"}, {7'b0, vec_valid}, 8'h01);
  endtask

  task automatic int_chk(input string tag, input logic exp);
    step(2);
    chk(tag, {7'b0, int_out}, {7'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; ack = 1'b0;
    wr_data = 8'h00; irq_in = 8'h00;
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk("R1 int_out after reset", {7'b0, int_out}, 8'h00);
    chk("R1 vec_valid after reset", {7'b0, vec_valid}, 8'h00);
    rd(1'b0, v); chk("R1 IRR after reset", v, 8'h00);
    rd(1'b1, v); chk("R1 IMR after reset", v, 8'h00);

    // R2 setup: base 0x40, final word present, plain modes
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R2 IMR after setup", v, 8'h00);

    // R3 R4 R5 R9 sweep over every line
    for (int l = 0; l < 8; l++) begin
      pulse(8'(1 << l));
      int_chk($sformatf("R4 int line %0d", l), 1'b1);
      rd(1'b0, v); chk($sformatf("R3 IRR line %0d", l), v, 8'(1 << l));
      ack_chk($sformatf("R5 ack line %0d", l), 8'h40 | 8'(l));
      rd(1'b0, v); chk($sformatf("R5 IRR cleared line %0d", l), v, 8'h00);
      rd_isr(v); chk($sformatf("R5 ISR line %0d", l), v, 8'(1 << l));
      wr(1'b0, 8'h20);
      rd_isr(v); chk($sformatf("R9 EOI line %0d", l), v, 8'h00);
    end
    step(2);
    chk("R5 vec_valid drops", {7'b0, vec_valid}, 8'h00);

    // R3 held level does not re-latch
    irq_in = 8'h01; step(1);
    ack_chk("R3 first edge", 8'h40);
    wr(1'b0, 8'h20);
    step(3);
    rd(1'b0, v); chk("R3 held level", v, 8'h00);
    irq_in = 8'h00; step(1);

    // R4 masking
    wr(1'b1, 8'hFF);
    pulse(8'h08);
    int_chk("R4 masked no int", 1'b0);
    rd(1'b0, v); chk("R4 masked still latched", v, 8'h08);
    rd(1'b1, v); chk("R2 IMR readback", v, 8'hFF);
    wr(1'b1, 8'hF7);
    int_chk("R4 unmasked int", 1'b1);
    ack_chk("R4 unmasked ack", 8'h43);
    wr(1'b0, 8'h20); wr(1'b1, 8'h00);

    // R4 R6 priority, nesting and spurious acknowledge
    pulse(8'h24);
    ack_chk("R4 line 2 beats 5", 8'h42);
    int_chk("R4 lower blocked by service", 1'b0);
    ack_chk("R6 spurious", 8'h47);
    rd_isr(v); chk("R6 ISR kept", v, 8'h04);
    rd(1'b0, v); chk("R6 IRR kept", v, 8'h20);
    wr(1'b0, 8'h20);
    int_chk("R9 after EOI int", 1'b1);
    ack_chk("R4 line 5 after EOI", 8'h45);
    wr(1'b0, 8'h20);

    // R11 R10 R9 rotation
    wr(1'b0, 8'hC4);
    pulse(8'h42);
    ack_chk("R11 set priority", 8'h46);
    int_chk("R11 line 1 blocked", 1'b0);
    wr(1'b0, 8'hE6);
    rd_isr(v); chk("R10 specific rotate clears", v, 8'h00);
    int_chk("R10 rotated int", 1'b1);
    ack_chk("R10 line 1 after rotate", 8'h41);
    wr(1'b0, 8'hA0);
    rd_isr(v); chk("R9 rotate EOI clears", v, 8'h00);
    pulse(8'h06);
    ack_chk("R9 rotated winner", 8'h42);
    wr(1'b0, 8'h20);
    ack_chk("R9 next", 8'h41);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'hC7);

    // R11 no-op, R10 specific EOI
    pulse(8'h10);
    ack_chk("R11 ack", 8'h44);
    wr(1'b0, 8'h40);
    rd_isr(v); chk("R11 code 2 no-op", v, 8'h10);
    wr(1'b0, 8'h20);
    pulse(8'h08);
    ack_chk("R10 ack", 8'h43);
    wr(1'b0, 8'h63);
    rd_isr(v); chk("R10 specific EOI", v, 8'h00);

    // R12 special mask
    pulse(8'h02);
    ack_chk("R12 ack line 1", 8'h41);
    pulse(8'h10);
    int_chk("R12 blocked before", 1'b0);
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h68);
    int_chk("R12 special mask int", 1'b1);
    ack_chk("R12 ack line 4", 8'h44);
    rd_isr(v); chk("R12 ISR both", v, 8'h12);
    wr(1'b0, 8'h48); wr(1'b0, 8'h64); wr(1'b0, 8'h61); wr(1'b1, 8'h00);

    // R13 poll
    pulse(8'h08);
    int_chk("R13 int before poll", 1'b1);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); chk("R13 poll line", v, 8'h03);
    rd(1'b0, v); chk("R13 IRR after poll", v, 8'h00);
    int_chk("R13 int after poll", 1'b0);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); chk("R13 poll empty", v, 8'h07);

    // R1 setup-start clears; R7 R8 auto-EOI with rotation
    wr(1'b1, 8'h55);
    pulse(8'h01);
    step(2);
    wr(1'b0, 8'h11);
    chk("R1 int low after setup start", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h40); wr(1'b1, 8'h02);
    rd(1'b1, v); chk("R1 IMR cleared", v, 8'h00);
    rd(1'b0, v); chk("R1 IRR cleared", v, 8'h00);
    wr(1'b0, 8'h80);
    pulse(8'h01);
    ack_chk("R7 ack", 8'h40);
    rd_isr(v); chk("R7 ISR stays clear", v, 8'h00);
    pulse(8'h03);
    ack_chk("R8 rotated pick", 8'h41);
    ack_chk("R8 second pick", 8'h40);
    wr(1'b0, 8'h00);
    pulse(8'h02);
    ack_chk("R8 rotation off ack", 8'h41);
    pulse(8'h06);
    ack_chk("R8 offset kept", 8'h41);
    ack_chk("R8 rest", 8'h42);

    // R14 special nested
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h10);
    pulse(8'h04);
    ack_chk("R14 first", 8'h42);
    pulse(8'h04);
    int_chk("R14 re-entry int", 1'b1);
    ack_chk("R14 second", 8'h42);

    // R2 short setup without final word, base low bits dropped
    wr(1'b0, 8'h10); wr(1'b1, 8'h87); wr(1'b1, 8'h33);
    rd(1'b1, v); chk("R2 IMR after short setup", v, 8'h33);
    pulse(8'h04);
    ack_chk("R2 base low bits zero", 8'h82);
    rd_isr(v); chk("R2 auto-EOI off", v, 8'h04);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule